// File: doc/BRIEF.md
# Time-Sliced Link Word Unpacker

This block turns a stream of 64-bit words from one time-multiplexed input fiber into 64-bit physics objects, each marked by a one-cycle valid pulse. Some object formats are wider than one link word: 96-bit tracks and 128-bit calorimeter and muon objects. These formats are the 64-bit object with zero padding above it. The block gathers the words of each object, keeps the low 64 bits, and checks that the padding really is zero. A nonzero padding field sets a sticky error flag, and the object is still delivered.

The object format is fixed when the block is built, through the parameter `FMT`. Track words are packed three link words to two objects. Calorimeter links carry one filler word after every two object words. Muon objects take two words each. A start-of-packet marker on a valid word restarts the word count, so the grouping and the filler position stay aligned with the sender. One instance serves one fiber. A sector that uses several fibers per time slice uses one instance for each fiber.

Top module: `link_unpacker`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `obj_valid` and `fmt_err` are 0.
- R2: In track format (`FMT` = FMT_TRACK, encoding 0), every group of three accepted words w0, w1, w2 yields two objects. The first object is w0 and its padding is w1[31:0]. The second object is {w2[31:0], w1[63:32]} and its padding is w2[63:32].
- R3: In calo format (`FMT` = FMT_CALO, encoding 1), each group is w0, w1 and a filler. The object is w0 and its padding is all of w1. The filler word yields no object and never affects `fmt_err`, whatever it contains.
- R4: In muon format (`FMT` = FMT_MUON, encoding 2), each pair of accepted words w0, w1 yields one object, w0, and its padding is all of w1.
- R5: An object appears on `obj_data` with `obj_valid` high for exactly one cycle. That cycle is the one after the clock edge that accepts the object's last word. `obj_valid` is low on every other cycle.
- R6: A cycle with `in_valid` low produces no object. It leaves the partial object and the word count unchanged.
- R7: A word with `in_valid` and `in_sop` both high is taken as the first word of a new group. Any partly gathered object is discarded, and no object is output for that word.
- R8: When the padding field of an object is nonzero, `fmt_err` rises in the same cycle as that object's `obj_valid`, and the object is still delivered.
- R9: Once set, `fmt_err` stays high until reset.
- R10: `in_sop` has no effect while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Link word present this cycle |
| in_sop | input | 1 | Word is the first of a packet (qualified by in_valid) |
| in_data | input | 64 | Link word |
| obj_valid | output | 1 | One-cycle pulse: obj_data holds a new object |
| obj_data | output | 64 | Unpacked object (low 64 bits of the wide format) |
| fmt_err | output | 1 | Sticky flag: a padding field was nonzero |

## Verification
Two functions can fall in the same cycle: realignment by start of packet, and completion of an object. If a start-of-packet word lands on the slot that would finish an object or be the filler, the realignment must win. No object is produced, and the next word completes the restarted object. The bench provokes this in each format by restarting a group at its second or third slot, and expects silence on that cycle and the new object one word later. It also pairs object delivery with a padding error, where the object must arrive unchanged in the same cycle as the error flag rises.

// File: rtl/lu_pkg.sv
package lu_pkg;

  localparam int unsigned OBJ_W  = 64;
  localparam int unsigned HALF_W = OBJ_W / 2;

  typedef enum logic [1:0] {
    FMT_TRACK = 2'd0,
    FMT_CALO  = 2'd1,
    FMT_MUON  = 2'd2
  } fmt_e;

  typedef struct packed {
    logic             emit;
    logic             pad_bad;
    logic [OBJ_W-1:0] obj;
  } slot_res_t;

  // words per group on the link for a given format
  function automatic int unsigned group_len(fmt_e f);
    return (f == FMT_MUON) ? 2 : 3;
  endfunction

  // slot that carries no object content at all
  function automatic logic is_filler(fmt_e f, logic [1:0] ph);
    return (f == FMT_CALO) && (ph == 2'd2);
  endfunction

  // decide what a word in slot ph completes, given the previous word
  function automatic slot_res_t decode_slot(fmt_e f, logic [1:0] ph,
                                            logic [OBJ_W-1:0] prev,
                                            logic [OBJ_W-1:0] cur);
    slot_res_t r;
    r = '0;
    unique case (f)
      FMT_TRACK: begin
        if (ph == 2'd1) begin
          r.emit    = 1'b1;
          r.obj     = prev;
          r.pad_bad = |cur[HALF_W-1:0];
        end else if (ph == 2'd2) begin
          r.emit    = 1'b1;
          r.obj     = {cur[HALF_W-1:0], prev[OBJ_W-1:HALF_W]};
          r.pad_bad = |cur[OBJ_W-1:HALF_W];
        end
      end
      FMT_CALO, FMT_MUON: begin
        if (ph == 2'd1) begin
          r.emit    = 1'b1;
          r.obj     = prev;
          r.pad_bad = |cur;
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lu_phase.sv
module lu_phase #(
  parameter int unsigned GROUP_LEN = 3,
  localparam int unsigned PW = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sop,
  output logic [PW-1:0] cur_phase,
  output logic          last_slot
);

  logic [PW-1:0] phase_q;

  assign cur_phase = in_sop ? '0 : phase_q;
  assign last_slot = (cur_phase == PW'(GROUP_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (in_valid) phase_q <= last_slot ? '0 : cur_phase + PW'(1);
  end

endmodule

// File: rtl/lu_hold.sv
module lu_hold #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] prev_word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prev_word <= '0;
    else if (in_valid) prev_word <= in_data;
  end

endmodule

// File: rtl/lu_outreg.sv
module lu_outreg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         pad_bad,
  input  logic [W-1:0] obj,
  output logic         obj_valid,
  output logic [W-1:0] obj_data,
  output logic         fmt_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obj_valid <= 1'b0;
      obj_data  <= '0;
      fmt_err   <= 1'b0;
    end else begin
      obj_valid <= fire;
      if (fire) obj_data <= obj;
      fmt_err   <= fmt_err | (fire & pad_bad);
    end
  end

endmodule

// File: rtl/link_unpacker.sv
module link_unpacker #(
  parameter lu_pkg::fmt_e FMT = lu_pkg::FMT_TRACK,
  parameter int unsigned  W   = lu_pkg::OBJ_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_sop,
  input  logic [W-1:0] in_data,
  output logic         obj_valid,
  output logic [W-1:0] obj_data,
  output logic         fmt_err
);
  import lu_pkg::*;

  localparam int unsigned GROUP = group_len(FMT);
  localparam int unsigned PW    = (GROUP > 1) ? $clog2(GROUP) : 1;

  logic [PW-1:0] cur_phase;
  logic          last_slot;
  logic [W-1:0]  prev_word;
  slot_res_t     res;

  // named internal events for the checker
  logic          word_fire;
  logic          filler_slot;
  logic          group_end;

  lu_phase #(.GROUP_LEN(GROUP)) u_phase (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .cur_phase(cur_phase), .last_slot(last_slot)
  );

  lu_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .prev_word(prev_word)
  );

  assign res         = decode_slot(FMT, 2'(cur_phase), prev_word, in_data);
  assign word_fire   = in_valid & res.emit;
  assign filler_slot = in_valid & is_filler(FMT, 2'(cur_phase));
  assign group_end   = in_valid & last_slot;

  lu_outreg #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .fire(word_fire), .pad_bad(res.pad_bad),
    .obj(res.obj), .obj_valid(obj_valid), .obj_data(obj_data),
    .fmt_err(fmt_err)
  );

endmodule

// File: rtl/link_unpacker_chk.sv
module link_unpacker_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_sop,
  input logic obj_valid,
  input logic fmt_err,
  input logic filler_slot,
  input logic word_fire
);

  // R1: reset clears the outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    !rst_n |=> (!obj_valid && !fmt_err));

  // R3: the filler slot never yields an object
  a_r3_filler_silent: assert property (@(posedge clk) disable iff (!rst_n)
    filler_slot |=> !obj_valid);

  // R5: an output pulse follows a completing word
  a_r5_pulse_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    obj_valid |-> $past(word_fire));

  // R6: no input word, no object
  a_r6_idle_no_object: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !obj_valid);

  // R7: a start-of-packet word never completes an object
  a_r7_sop_no_object: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop) |=> !obj_valid);

  // R8: the error flag rises only together with an object
  a_r8_err_with_object: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fmt_err) |-> obj_valid);

  // R9: the error flag is sticky
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |=> fmt_err);

endmodule

bind link_unpacker link_unpacker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
  .obj_valid(obj_valid), .fmt_err(fmt_err), .filler_slot(filler_slot),
  .word_fire(word_fire)
);

// File: tb/link_unpacker_test.sv
module link_unpacker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v  [3];
  logic        s  [3];
  logic [63:0] d  [3];
  logic        ov [3];
  logic [63:0] od [3];
  logic        oe [3];
  bit          exp_err [3];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #5 clk = ~clk;

  // k=0 track, k=1 calo, k=2 muon
  link_unpacker #(.FMT(lu_pkg::FMT_TRACK)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(v[0]), .in_sop(s[0]), .in_data(d[0]),
    .obj_valid(ov[0]), .obj_data(od[0]), .fmt_err(oe[0]));
  link_unpacker #(.FMT(lu_pkg::FMT_CALO)) uut_calo (
    .clk(clk), .rst_n(rst_n), .in_valid(v[1]), .in_sop(s[1]), .in_data(d[1]),
    .obj_valid(ov[1]), .obj_data(od[1]), .fmt_err(oe[1]));
  link_unpacker #(.FMT(lu_pkg::FMT_MUON)) uut_muon (
    .clk(clk), .rst_n(rst_n), .in_valid(v[2]), .in_sop(s[2]), .in_data(d[2]),
    .obj_valid(ov[2]), .obj_data(od[2]), .fmt_err(oe[2]));

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [31:0] pad32(bit bad);
    return bad ? ($urandom | 32'h1) : 32'h0;
  endfunction

  // one cycle on fiber k, then compare at the following falling edge
  task automatic step(input int k, input bit vv, input bit ss,
                      input logic [63:0] dd, input bit ev,
                      input logic [63:0] eo, input bit err_set,
                      input string req);
    v[k] = vv; s[k] = ss; d[k] = dd;
    @(negedge clk);
    exp_err[k] = exp_err[k] | err_set;
    n_chk++;
    if (ov[k] !== ev || (ev && od[k] !== eo) || oe[k] !== exp_err[k]) begin
      n_bad++;
      $display("FAIL %s fiber=%0d valid=%0b/%0b data=%h/%h err=%0b/%0b",
               req, k, ov[k], ev, od[k], eo, oe[k], exp_err[k]);
    end
    v[k] = 1'b0; s[k] = 1'b0;
  endtask

  task automatic idle(input int k, input bit ss, input string req);
    step(k, 1'b0, ss, rnd64(), 1'b0, 64'h0, 1'b0, req);
  endtask

  task automatic gaps(input int k);
    while ($urandom_range(0, 3) == 0) idle(k, $urandom_range(0, 1) == 1, "R6 R10");
  endtask

  task automatic send_track(input bit sop, input bit bad_a, input bit bad_b);
    logic [63:0] a, b;
    a = rnd64(); b = rnd64();
    step(0, 1, sop, a, 0, 0, 0, "R2");
    gaps(0);
    step(0, 1, 0, {b[31:0], pad32(bad_a)}, 1, a, bad_a, "R2 R5 R8");
    gaps(0);
    step(0, 1, 0, {pad32(bad_b), b[63:32]}, 1, b, bad_b, "R2 R5 R8");
    gaps(0);
  endtask

  task automatic send_calo(input bit sop, input bit bad);
    logic [63:0] a;
    a = rnd64();
    step(1, 1, sop, a, 0, 0, 0, "R3");
    gaps(1);
    step(1, 1, 0, {pad32(bad), pad32(bad)}, 1, a, bad, "R3 R5 R8");
    gaps(1);
    step(1, 1, 0, rnd64() | 64'h1, 0, 0, 0, "R3");
    gaps(1);
  endtask

  task automatic send_muon(input bit sop, input bit bad);
    logic [63:0] a;
    a = rnd64();
    step(2, 1, sop, a, 0, 0, 0, "R4");
    gaps(2);
    step(2, 1, 0, {pad32(bad), 32'h0}, 1, a, bad, "R4 R5 R8");
    gaps(2);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      v[k] = 0; s[k] = 0; d[k] = '0; exp_err[k] = 0;
    end
    @(negedge clk); @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      n_chk++;
      if (ov[k] !== 1'b0 || oe[k] !== 1'b0) begin
        n_bad++;
        $display("FAIL R1 fiber=%0d valid=%0b/0 err=%0b/0", k, ov[k], oe[k]);
      end
    end
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) idle(k, 0, "R1");
  endtask

  initial begin
    logic [63:0] a, b;
    void'($urandom(32'd4242));
    for (int k = 0; k < 3; k++) begin v[k] = 0; s[k] = 0; d[k] = '0; end
    do_reset();

    // clean random traffic, each packet opens with a start marker
    for (int i = 0; i < 150; i++) begin
      send_track(i % 5 == 0, 0, 0);
      send_calo(i % 4 == 0, 0);
      send_muon(i % 6 == 0, 0);
    end

    // R7 track: restart at slot 2 drops the second object
    a = rnd64(); b = rnd64();
    step(0, 1, 1, a, 0, 0, 0, "R7");
    step(0, 1, 0, {b[31:0], 32'h0}, 1, a, 0, "R7");
    a = rnd64();
    step(0, 1, 1, a, 0, 0, 0, "R7 restart in slot 2");
    step(0, 1, 0, {32'h0, 32'h0}, 1, a, 0, "R7 realigned");
    // R7 track: restart at slot 1
    step(0, 1, 1, rnd64(), 0, 0, 0, "R7");
    a = rnd64();
    step(0, 1, 1, a, 0, 0, 0, "R7 restart in slot 1");
    step(0, 1, 0, 64'h0, 1, a, 0, "R7 realigned");
    // R10: start marker without valid is ignored mid-group
    step(0, 1, 0, {32'h0, 32'h0}, 1, 64'h0, 0, "R2");
    a = rnd64();
    step(0, 1, 1, a, 0, 0, 0, "R10");
    idle(0, 1, "R10");
    step(0, 1, 0, 64'h0, 1, a, 0, "R10 sop ignored when idle");

    // R7 calo: restart on the filler slot
    a = rnd64();
    step(1, 1, 1, a, 0, 0, 0, "R7");
    step(1, 1, 0, 64'h0, 1, a, 0, "R7");
    b = rnd64();
    step(1, 1, 1, b, 0, 0, 0, "R7 restart on filler");
    step(1, 1, 0, 64'h0, 1, b, 0, "R7 realigned");
    step(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R3 filler ignored");
    // R7 muon: restart at slot 1
    step(2, 1, 1, rnd64(), 0, 0, 0, "R7");
    a = rnd64();
    step(2, 1, 1, a, 0, 0, 0, "R7 restart in slot 1");
    step(2, 1, 0, 64'h0, 1, a, 0, "R7 realigned");

    // R8 / R9: padding errors, then clean objects keep the flag
    send_track(1, 0, 1);
    send_calo(1, 1);
    send_muon(1, 1);
    for (int i = 0; i < 20; i++) begin
      send_track(0, 0, 0);
      send_calo(0, 0);
      send_muon(0, 0);
    end
    // mixed random with occasional errors after a fresh reset
    do_reset();
    send_track(1, 1, 0);
    for (int i = 0; i < 100; i++) begin
      send_track(0, $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0);
      send_calo(0, $urandom_range(0, 15) == 0);
      send_muon(0, $urandom_range(0, 15) == 0);
    end
    do_reset();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule